// File: doc/BRIEF.md
# Timer Compare Unit with Trigger Output

This block holds a programmable compare value and checks it against an external free-running timer on every clock cycle. When the timer reaches the compare value, the block can do one of three things to an output pin: drive it high, drive it low, or leave it alone. On every match it also sets a sticky interrupt flag, which software clears with a strobe.

A fourth compare mode turns the match into a special event. In that mode the block sends a one-cycle reset strobe back to the shared timer. If the external converter is enabled, the same edge also emits a one-cycle conversion-start strobe.

The timer counter and the converter live outside the block. The host writes the compare value and the mode through two write ports.

Top module: `ctu_compare_unit`

## Requirements
- R1: After reset, `pin_out`, `irq_flag`, `timer_rst` and `conv_start` are all 0. The compare value is 0 and the mode is off (4'h0).
- R2: While a compare mode is active, the timer is compared with the compare value on every cycle, not only when a register is written. A match is registered on the edge at the end of the cycle in which the timer first shows the equal value, and the outputs show it right after that edge.
- R3: Mode 4'h8 (set on match). Writing this mode drives `pin_out` to 0 on the next edge. A match drives `pin_out` to 1.
- R4: Mode 4'h9 (clear on match). Writing this mode drives `pin_out` to 1 on the next edge. A match drives `pin_out` to 0.
- R5: Mode 4'hA (flag only). Writing this mode leaves `pin_out` at its current level, and a match also leaves it unchanged.
- R6: Every match sets `irq_flag`, which stays 1 until `flag_clr` is pulsed. If a match and `flag_clr` fall on the same cycle, the flag ends up set.
- R7: A match happens only once per arrival of the timer at the compare value. If the timer holds that value for several cycles, the block produces a single event.
- R8: Mode 4'hB (special event). A match produces a `timer_rst` pulse exactly one cycle wide, and `pin_out` is left unchanged.
- R9: `conv_start` pulses for one cycle together with `timer_rst`, and only when `adc_en` is 1 in the match cycle. It stays 0 in every mode other than 4'hB.
- R10: A compare write takes effect on the next edge and never produces a match by itself. A match needs the timer to move onto the compare value after the write.
- R11: Mode 4'h0 and every undefined mode code produce no match. The flag, the pin and the strobes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Current value of the external timer |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | New compare value |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 4 | New mode code |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| adc_en | input | 1 | Converter enable from the converter block |
| pin_out | output | 1 | Compare output pin level |
| irq_flag | output | 1 | Sticky match interrupt flag |
| timer_rst | output | 1 | One-cycle reset strobe to the timer |
| conv_start | output | 1 | One-cycle conversion-start strobe |

## Verification
The bench holds the timer on the compare value for several cycles. A detector that only tests for equality would fire again on every one of those cycles, and the repeated trigger shows it.

It also writes a compare value equal to the current timer. A design that treats the write as a match would raise the flag with no timer movement.

A match arriving together with the clear strobe must leave the flag set; a design with the wrong priority would lose the interrupt.

Finally, the bench toggles `adc_en` across special-event matches and tries the converter enable in a pin mode. A design that decodes the converter gate wrongly would start conversions it should not start.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_OFF  = 4'h0;
    localparam logic [MODE_W-1:0] MODE_SET  = 4'h8;
    localparam logic [MODE_W-1:0] MODE_CLR  = 4'h9;
    localparam logic [MODE_W-1:0] MODE_FLAG = 4'hA;
    localparam logic [MODE_W-1:0] MODE_EVT  = 4'hB;

    typedef struct packed {
        logic active;
        logic set_high;
        logic drive_low;
        logic special;
    } ctu_action_t;

endpackage

// File: rtl/ctu_mode_decode.sv
module ctu_mode_decode
    import ctu_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output ctu_action_t       act
);
    always_comb begin
        act = '0;
        unique case (mode)
            MODE_SET:  begin act.active = 1'b1; act.set_high  = 1'b1; end
            MODE_CLR:  begin act.active = 1'b1; act.drive_low = 1'b1; end
            MODE_FLAG: begin act.active = 1'b1; end
            MODE_EVT:  begin act.active = 1'b1; act.special   = 1'b1; end
            default:   act = '0;
        endcase
    end
endmodule

// File: rtl/ctu_match_detect.sv
module ctu_match_detect #(
    parameter int TMR_W = 16
) (
    input  logic [TMR_W-1:0] timer_val,
    input  logic [TMR_W-1:0] cmp_val,
    input  logic [TMR_W-1:0] prev_val,
    input  logic             done,
    input  logic             active,
    output logic             new_val,
    output logic             hit
);
    logic equal;

    always_comb begin
        equal   = (timer_val == cmp_val);
        new_val = (timer_val != prev_val);
        hit     = active && equal && (new_val || !done);
    end
endmodule

// File: rtl/ctu_trigger_gen.sv
module ctu_trigger_gen #(
    parameter bit CONV_EN = 1'b1
) (
    input  logic hit,
    input  logic special,
    input  logic adc_en,
    output logic trig,
    output logic conv
);
    always_comb trig = hit && special;

    generate
        if (CONV_EN) begin : g_conv
            always_comb conv = hit && special && adc_en;
        end else begin : g_noconv
            always_comb conv = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ctu_compare_unit.sv
module ctu_compare_unit
    import ctu_pkg::*;
#(
    parameter int TMR_W   = 16,
    parameter bit CONV_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TMR_W-1:0]   timer_val,
    input  logic               cmp_wr,
    input  logic [TMR_W-1:0]   cmp_wdata,
    input  logic               mode_wr,
    input  logic [MODE_W-1:0]  mode_wdata,
    input  logic               flag_clr,
    input  logic               adc_en,
    output logic               pin_out,
    output logic               irq_flag,
    output logic               timer_rst,
    output logic               conv_start
);

    typedef struct packed {
        logic [TMR_W-1:0]  cmp;
        logic [MODE_W-1:0] mode;
        logic [TMR_W-1:0]  prev;
        logic              done;
        logic              pin;
        logic              flag;
        logic              trig;
        logic              conv;
    } ctu_state_t;

    ctu_state_t  st_q, st_d;
    ctu_action_t act_cur, act_new;
    logic        hit, new_val, trig_w, conv_w;

    ctu_mode_decode u_dec_cur (.mode(st_q.mode),  .act(act_cur));
    ctu_mode_decode u_dec_new (.mode(mode_wdata), .act(act_new));

    ctu_match_detect #(.TMR_W(TMR_W)) u_match (
        .timer_val (timer_val),
        .cmp_val   (st_q.cmp),
        .prev_val  (st_q.prev),
        .done      (st_q.done),
        .active    (act_cur.active),
        .new_val   (new_val),
        .hit       (hit)
    );

    ctu_trigger_gen #(.CONV_EN(CONV_EN)) u_trig (
        .hit     (hit),
        .special (act_cur.special),
        .adc_en  (adc_en),
        .trig    (trig_w),
        .conv    (conv_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = timer_val;
        st_d.trig = trig_w;
        st_d.conv = conv_w;
        if (cmp_wr)  st_d.cmp  = cmp_wdata;
        if (mode_wr) st_d.mode = mode_wdata;

        if (hit || cmp_wr || mode_wr) st_d.done = 1'b1;
        else if (new_val)             st_d.done = 1'b0;

        if (mode_wr) begin
            if (act_new.set_high)       st_d.pin = 1'b0;
            else if (act_new.drive_low) st_d.pin = 1'b1;
        end else if (hit) begin
            if (act_cur.set_high)       st_d.pin = 1'b1;
            else if (act_cur.drive_low) st_d.pin = 1'b0;
        end

        if (hit)           st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_OFF;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out    = st_q.pin;
    assign irq_flag   = st_q.flag;
    assign timer_rst  = st_q.trig;
    assign conv_start = st_q.conv;

    p_match_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq_flag);
    p_pin_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act_cur.set_high && !mode_wr) |=> pin_out);
    p_pin_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act_cur.drive_low && !mode_wr) |=> !pin_out);
    p_pin_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !act_cur.set_high && !act_cur.drive_low && !mode_wr) |=> $stable(pin_out));
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);
    p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rst |=> !timer_rst);
    p_conv_with_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> timer_rst);
    p_conv_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !adc_en) |=> !conv_start);
    p_wr_no_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> ($stable(timer_val) -> !hit));
    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_cur.active && !flag_clr) |=> ($stable(irq_flag) && !timer_rst));

endmodule

// File: tb/tb_ctu_compare_unit.sv
module tb_ctu_compare_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = '0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        adc_en = 1'b0;
    logic        pin_out, irq_flag, timer_rst, conv_start;

    typedef struct {
        logic  pin;
        logic  flag;
        logic  trig;
        logic  conv;
        string req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ctu_compare_unit dut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .flag_clr(flag_clr), .adc_en(adc_en),
        .pin_out(pin_out), .irq_flag(irq_flag),
        .timer_rst(timer_rst), .conv_start(conv_start)
    );

    task automatic step(input logic [15:0] t, input logic cw, input logic [15:0] cd,
                        input logic mw, input logic [3:0] md, input logic clr,
                        input logic adc, input logic ep, input logic ef,
                        input logic et, input logic ec, input string r);
        exp_t e;
        @(negedge clk);
        timer_val = t; cmp_wr = cw; cmp_wdata = cd;
        mode_wr = mw; mode_wdata = md; flag_clr = clr; adc_en = adc;
        e.pin = ep; e.flag = ef; e.trig = et; e.conv = ec; e.req = r;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if ({pin_out, irq_flag, timer_rst, conv_start} !== {e.pin, e.flag, e.trig, e.conv}) begin
                    errors++;
                    $display("FAIL %s: pin/flag/trig/conv actual %b%b%b%b expected %b%b%b%b",
                             e.req, pin_out, irq_flag, timer_rst, conv_start,
                             e.pin, e.flag, e.trig, e.conv);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if ({pin_out, irq_flag, timer_rst, conv_start} !== 4'b0000) begin
            errors++;
            $display("FAIL R1: actual %b%b%b%b expected 0000", pin_out, irq_flag, timer_rst, conv_start);
        end
        //     tmr  cw cdata mw md   clr adc  pin flg trg cnv
        step(0,  0, 0,  0, 4'h0, 0, 0,  0, 0, 0, 0, "R1");
        step(0,  1, 5,  0, 4'h0, 0, 0,  0, 0, 0, 0, "R10");
        step(0,  0, 0,  1, 4'h8, 0, 0,  0, 0, 0, 0, "R3");
        step(3,  0, 0,  0, 4'h0, 0, 0,  0, 0, 0, 0, "R2");
        step(4,  0, 0,  0, 4'h0, 0, 0,  0, 0, 0, 0, "R2");
        step(5,  0, 0,  0, 4'h0, 0, 0,  1, 1, 0, 0, "R3");
        step(5,  0, 0,  0, 4'h0, 0, 0,  1, 1, 0, 0, "R7");
        step(6,  0, 0,  0, 4'h0, 0, 0,  1, 1, 0, 0, "R6");
        step(6,  0, 0,  0, 4'h0, 1, 0,  1, 0, 0, 0, "R6");
        step(6,  0, 0,  1, 4'h9, 0, 0,  1, 0, 0, 0, "R4");
        step(5,  0, 0,  0, 4'h0, 0, 0,  0, 1, 0, 0, "R4");
        step(7,  0, 0,  0, 4'h0, 1, 0,  0, 0, 0, 0, "R6");
        step(5,  0, 0,  0, 4'h0, 1, 0,  0, 1, 0, 0, "R6");
        step(5,  0, 0,  1, 4'h9, 0, 0,  1, 1, 0, 0, "R4");
        step(5,  0, 0,  1, 4'hA, 0, 0,  1, 1, 0, 0, "R5");
        step(5,  0, 0,  0, 4'h0, 1, 0,  1, 0, 0, 0, "R5");
        step(6,  0, 0,  0, 4'h0, 0, 0,  1, 0, 0, 0, "R5");
        step(5,  0, 0,  0, 4'h0, 0, 0,  1, 1, 0, 0, "R5");
        step(5,  0, 0,  1, 4'hB, 1, 0,  1, 0, 0, 0, "R8");
        step(6,  0, 0,  0, 4'h0, 0, 0,  1, 0, 0, 0, "R8");
        step(5,  0, 0,  0, 4'h0, 0, 0,  1, 1, 1, 0, "R8");
        step(5,  0, 0,  0, 4'h0, 0, 0,  1, 1, 0, 0, "R7");
        step(6,  0, 0,  0, 4'h0, 0, 1,  1, 1, 0, 0, "R9");
        step(5,  0, 0,  0, 4'h0, 0, 1,  1, 1, 1, 1, "R9");
        step(0,  0, 0,  0, 4'h0, 0, 1,  1, 1, 0, 0, "R8");
        step(9,  0, 0,  0, 4'h0, 1, 0,  1, 0, 0, 0, "R6");
        step(9,  1, 9,  0, 4'h0, 0, 0,  1, 0, 0, 0, "R10");
        step(9,  0, 0,  0, 4'h0, 0, 0,  1, 0, 0, 0, "R10");
        step(8,  0, 0,  0, 4'h0, 0, 0,  1, 0, 0, 0, "R10");
        step(9,  0, 0,  0, 4'h0, 0, 0,  1, 1, 1, 0, "R10");
        step(11, 1, 12, 0, 4'h0, 1, 0,  1, 0, 0, 0, "R10");
        step(12, 0, 0,  0, 4'h0, 0, 0,  1, 1, 1, 0, "R10");
        step(12, 0, 0,  1, 4'h0, 1, 0,  1, 0, 0, 0, "R11");
        step(11, 0, 0,  0, 4'h0, 0, 1,  1, 0, 0, 0, "R11");
        step(12, 0, 0,  0, 4'h0, 0, 1,  1, 0, 0, 0, "R11");
        step(0,  0, 0,  1, 4'h3, 0, 1,  1, 0, 0, 0, "R11");
        step(12, 0, 0,  0, 4'h0, 0, 1,  1, 0, 0, 0, "R11");
        step(0,  0, 0,  1, 4'h8, 0, 1,  0, 0, 0, 0, "R3");
        step(12, 0, 0,  0, 4'h0, 0, 1,  1, 1, 0, 0, "R9");
        step(12, 0, 0,  0, 4'h0, 0, 0,  1, 1, 0, 0, "R7");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule